// File: doc/BRIEF.md
# Binary Field Multiplier over GF(2^m)

This block multiplies two elements of the binary extension field GF(2^m) held in polynomial basis. It returns Z(x) = U(x)·V(x) mod f(x). The parameter `FIELD_M` picks both the field size and its fixed reduction polynomial. For `FIELD_M` = 163 the polynomial is x^163 + x^7 + x^6 + x^3 + 1. For `FIELD_M` = 233 it is x^233 + x^74 + 1. Every iteration handles one bit of V, starting at bit 0. An AND block gates the running copy of U by that bit, and an XOR adds the gated copy into the accumulator. The copy of U is then multiplied by x: it is shifted left one place, and a second AND block folds the bit that leaves the top back in through the tap mask. No multiplexer is needed, and the running copy always stays below degree m.

The parameter `SERIAL_FORM` chooses one of two datapaths:

- **Bit-serial:** one step per clock, so a product takes m cycles.
- **Unrolled:** all m steps in one combinational chain, with the product registered one cycle after `start`.

The parameter `SQUARE_ONLY` ties the second operand to the first, which turns the same structure into a squarer.

Top module: `gf2m_mul`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `prod`, `busy` and `done` are all 0.
- R2: With `FIELD_M` = 163, multiplying x^162 (only bit 162 set) by x (only bit 1 set) gives 0xC9, which is bits 7, 6, 3 and 0.
- R3: With `FIELD_M` = 233, multiplying x^232 by x gives x^74 + 1, which is bits 74 and 0.
- R4: Multiplying any U by 1 (only bit 0 set) returns U. Multiplying any U by 0 returns 0.
- R5: Swapping the two operands gives the same product.
- R6: For random operands, `prod` equals the full polynomial product reduced modulo the selected polynomial.
- R7: In the bit-serial form, a `start` sampled while idle raises `busy` on the next cycle. `done` is then high for exactly one cycle, and the `prod` update and the `done` pulse appear exactly `FIELD_M` clock edges after the edge that accepted `start`. `busy` is low in the cycle where `done` is high.
- R8: In the bit-serial form, a `start` that arrives while `busy` is high is ignored. The result and the timing of `done` belong to the operation already running.
- R9: `prod` keeps its value in every cycle in which `done` is low, even when the operand inputs change.
- R10: In the unrolled form, `start` produces `done` and the product on the next clock edge, and `busy` stays low.
- R11: With `SQUARE_ONLY` = 1, `prod` is `op_a`·`op_a` mod f(x), and `op_b` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the operands and begins a product |
| op_a | input | FIELD_M | Operand U, coefficient of x^i at bit i |
| op_b | input | FIELD_M | Operand V, scanned from bit 0 upward |
| prod | output | FIELD_M | Product register |
| busy | output | 1 | Bit-serial product in progress |
| done | output | 1 | One-cycle pulse when `prod` is updated |

## Verification
The bench aims at the reduction boundary: a top-degree operand multiplied by x. If a tap sits in the wrong bit, or the bit that leaves the top is dropped instead of folded back, the result for that case is a single wrong constant. Random operands are compared with a reference that forms the whole double-width product first and then reduces it from the top degree downward. That comparison exposes an off-by-one in the scan direction or a missing final step. In the bit-serial form the bench counts the edges up to `done` and then sends a second `start` in the middle of a run. A design that reloads its operands on that `start` returns the wrong product or finishes late. The squarer instance is driven with a random `op_b`, so one that still reads that input gives a wrong result.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  localparam int MAX_M = 233;
  typedef logic [MAX_M-1:0] wide_t;

  // Low-order terms of the reduction polynomial (x^m itself is implicit).
  function automatic wide_t tap_mask(input int m);
    wide_t t;
    t = '0;
    case (m)
      163: begin t[7] = 1'b1; t[6] = 1'b1; t[3] = 1'b1; t[0] = 1'b1; end
      233: begin t[74] = 1'b1; t[0] = 1'b1; end
      default: t[0] = 1'b1;
    endcase
    return t;
  endfunction

  // Multiply by x, with the overflow term folded back through the taps.
  function automatic wide_t times_x(input wide_t u, input int m);
    wide_t lowm;
    wide_t top;
    lowm = (wide_t'(1) << m) - wide_t'(1);
    top  = {MAX_M{u[m-1]}};
    return ((u << 1) & lowm) ^ (tap_mask(m) & top);
  endfunction
endpackage

// File: rtl/gf_mac_step.sv
module gf_mac_step
  import gf2m_pkg::*;
#(
  parameter int FIELD_M = 163
) (
  input  logic [FIELD_M-1:0] acc_i,
  input  logic [FIELD_M-1:0] u_i,
  input  logic               vbit,
  output logic [FIELD_M-1:0] acc_o,
  output logic [FIELD_M-1:0] u_o
);
  localparam wide_t               TAPW = tap_mask(FIELD_M);
  localparam logic [FIELD_M-1:0] TAPS = TAPW[FIELD_M-1:0];

  // AND block 1 + XOR 1: conditional accumulate
  assign acc_o = acc_i ^ (u_i & {FIELD_M{vbit}});
  // shift + AND block 2 + XOR 2: multiply by x and reduce
  assign u_o   = {u_i[FIELD_M-2:0], 1'b0} ^ (TAPS & {FIELD_M{u_i[FIELD_M-1]}});
endmodule

// File: rtl/gf_mul_unrolled.sv
module gf_mul_unrolled #(
  parameter int FIELD_M = 163
) (
  input  logic [FIELD_M-1:0] a,
  input  logic [FIELD_M-1:0] b,
  output logic [FIELD_M-1:0] z
);
  logic [FIELD_M-1:0] acc_c [FIELD_M+1];
  logic [FIELD_M-1:0] u_c   [FIELD_M];

  assign acc_c[0] = '0;
  assign u_c[0]   = a;

  for (genvar i = 0; i < FIELD_M; i++) begin : g_step
    if (i < FIELD_M - 1) begin : g_full
      gf_mac_step #(.FIELD_M(FIELD_M)) u_step (
        .acc_i(acc_c[i]),
        .u_i  (u_c[i]),
        .vbit (b[i]),
        .acc_o(acc_c[i+1]),
        .u_o  (u_c[i+1])
      );
    end else begin : g_last
      assign acc_c[i+1] = acc_c[i] ^ (u_c[i] & {FIELD_M{b[i]}});
    end
  end

  assign z = acc_c[FIELD_M];
endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
  parameter int FIELD_M = 163
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_M-1:0] a,
  input  logic [FIELD_M-1:0] b,
  output logic [FIELD_M-1:0] prod,
  output logic               busy,
  output logic               done
);
  localparam int CW = $clog2(FIELD_M);

  logic [FIELD_M-1:0] acc_q, u_q, v_q;
  logic [FIELD_M-1:0] acc_n, u_n;
  logic [CW-1:0]      cnt_q;
  logic               accept, last_step;

  assign accept    = start && !busy;
  assign last_step = busy && (cnt_q == CW'(FIELD_M - 1));

  gf_mac_step #(.FIELD_M(FIELD_M)) u_step (
    .acc_i(acc_q),
    .u_i  (u_q),
    .vbit (v_q[0]),
    .acc_o(acc_n),
    .u_o  (u_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; u_q <= '0; v_q <= '0; cnt_q <= '0;
      prod  <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        acc_q <= '0;
        u_q   <= a;
        v_q   <= b;
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc_q <= acc_n;
        u_q   <= u_n;
        v_q   <= v_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
          prod <= acc_n;
        end
      end
    end
  end

  AST_CNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt_q == '0);                                   // R7
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && !done));                      // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> cnt_q == $past(cnt_q) + 1'b1); // R8
endmodule

// File: rtl/gf2m_mul.sv
module gf2m_mul #(
  parameter int FIELD_M     = 163,
  parameter bit SERIAL_FORM = 1'b1,
  parameter bit SQUARE_ONLY = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_M-1:0] op_a,
  input  logic [FIELD_M-1:0] op_b,
  output logic [FIELD_M-1:0] prod,
  output logic               busy,
  output logic               done
);
  logic [FIELD_M-1:0] b_eff;

  if (SQUARE_ONLY) begin : g_sq
    assign b_eff = op_a;
  end else begin : g_mul
    assign b_eff = op_b;
  end

  if (SERIAL_FORM) begin : g_serial
    gf_mul_serial #(.FIELD_M(FIELD_M)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a(op_a), .b(b_eff), .prod(prod), .busy(busy), .done(done)
    );
  end else begin : g_unrolled
    logic [FIELD_M-1:0] z_comb;
    logic [FIELD_M-1:0] prod_q;
    logic               done_q;

    gf_mul_unrolled #(.FIELD_M(FIELD_M)) u_core (
      .a(op_a), .b(b_eff), .z(z_comb)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prod_q <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= start;
        if (start) prod_q <= z_comb;
      end
    end

    assign prod = prod_q;
    assign done = done_q;
    assign busy = 1'b0;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);                                              // R10
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);                                    // R7
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(prod));                                       // R9
endmodule

// File: tb/sim_gf2m_mul.sv
module sim_gf2m_mul;
  localparam int M1 = 163;
  localparam int M2 = 233;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [M1-1:0] a1 = '0, b1 = '0;
  logic [M2-1:0] a2 = '0, b2 = '0;
  logic st0 = 0, st1 = 0, st3 = 0;
  logic [M1-1:0] p0, p1, p2;
  logic [M2-1:0] p3;
  logic bz0, bz1, bz2, bz3, dn0, dn1, dn2, dn3;

  int checks = 0;
  int fails  = 0;

  gf2m_mul #(.FIELD_M(M1), .SERIAL_FORM(1'b1), .SQUARE_ONLY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(st0), .op_a(a1), .op_b(b1),
    .prod(p0), .busy(bz0), .done(dn0));
  gf2m_mul #(.FIELD_M(M1), .SERIAL_FORM(1'b0), .SQUARE_ONLY(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(st1), .op_a(a1), .op_b(b1),
    .prod(p1), .busy(bz1), .done(dn1));
  gf2m_mul #(.FIELD_M(M1), .SERIAL_FORM(1'b0), .SQUARE_ONLY(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .start(st1), .op_a(a1), .op_b(b1),
    .prod(p2), .busy(bz2), .done(dn2));
  gf2m_mul #(.FIELD_M(M2), .SERIAL_FORM(1'b1), .SQUARE_ONLY(1'b0)) u3 (
    .clk(clk), .rst_n(rst_n), .start(st3), .op_a(a2), .op_b(b2),
    .prod(p3), .busy(bz3), .done(dn3));

  // Reference: full schoolbook product, then reduce from the top degree down.
  function automatic logic [M2-1:0] ref_mul(input logic [M2-1:0] a,
                                            input logic [M2-1:0] b, input int m);
    logic [2*M2-1:0] p;
    p = '0;
    for (int i = 0; i < m; i++)
      if (b[i]) p = p ^ ((2*M2)'(a) << i);
    for (int d = 2*m - 2; d >= m; d--) begin
      if (p[d]) begin
        p[d] = 1'b0;
        if (m == 163) begin
          p[d-163+7] ^= 1'b1; p[d-163+6] ^= 1'b1;
          p[d-163+3] ^= 1'b1; p[d-163]   ^= 1'b1;
        end else begin
          p[d-233+74] ^= 1'b1; p[d-233] ^= 1'b1;
        end
      end
    end
    return p[M2-1:0] & ((M2'(1) << m) - M2'(1));
  endfunction

  function automatic logic [M2-1:0] rnd(input int m);
    logic [M2-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r & ((M2'(1) << m) - M2'(1));
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [M2-1:0] act, input logic [M2-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial 163: returns product and edge count to done (expected M1+1 negedges).
  task automatic run_u0(input logic [M1-1:0] a, input logic [M1-1:0] b,
                        output logic [M1-1:0] r, output int cyc);
    @(negedge clk); a1 = a; b1 = b; st0 = 1;
    cyc = 0;
    @(negedge clk); st0 = 0; a1 = ~a; b1 = ~b; cyc = 1;
    while (!dn0 && cyc < 2000) begin @(negedge clk); cyc++; end
    r = p0;
  endtask

  task automatic run_u3(input logic [M2-1:0] a, input logic [M2-1:0] b,
                        output logic [M2-1:0] r, output int cyc);
    @(negedge clk); a2 = a; b2 = b; st3 = 1;
    @(negedge clk); st3 = 0; cyc = 1;
    while (!dn3 && cyc < 2000) begin @(negedge clk); cyc++; end
    r = p3;
  endtask

  task automatic run_u1(input logic [M1-1:0] a, input logic [M1-1:0] b);
    @(negedge clk); a1 = a; b1 = b; st1 = 1;
    @(negedge clk); st1 = 0;
  endtask

  localparam logic [M1-1:0] VA [NV] = '{
    163'h1, 163'h2, 163'h4_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000,
    163'h7_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 163'hC9,
    163'h5_5555_5555_5555_5555_5555_5555_5555_5555_5555_5555,
    163'h1234_5678_9ABC_DEF0, 163'h3_0000_0000_0000_0000_0000_0000_0000_0000_0000_0001};
  localparam logic [M1-1:0] VB [NV] = '{
    163'h3, 163'h4_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000, 163'h2,
    163'h7_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    163'h6_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000,
    163'h2_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA,
    163'hFEDC_BA98_7654_3210, 163'h1_0000_0000_0000_0000_0000_0000_0000_0000_0000_0003};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [M1-1:0] r, x, y, r2;
    logic [M2-1:0] q, e;
    int cyc;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(p0 == '0 && !bz0 && !dn0 && p1 == '0 && !dn1 && p3 == '0 && !bz3,
          "R1 reset", M2'(p0), '0);
    rst_n = 1;
    @(negedge clk);
    check(p0 == '0 && !bz0 && !dn0 && !dn1 && !dn3, "R1 after release", M2'(p0), '0);

    // Vector table walk through serial and unrolled forms (R6, R7, R10)
    for (int i = 0; i < NV; i++) begin
      e = ref_mul(M2'(VA[i]), M2'(VB[i]), M1);
      run_u0(VA[i], VB[i], r, cyc);
      check(r == e[M1-1:0], "R6 table serial", M2'(r), e);
      check(cyc == M1 + 1, "R7 serial latency", M2'(cyc), M2'(M1 + 1));
      @(negedge clk);
      check(!dn0, "R7 done one cycle", M2'(dn0), '0);
      run_u1(VA[i], VB[i]);
      check(dn1 && p1 == e[M1-1:0], "R10 table unrolled", M2'(p1), e);
      check(!bz1, "R10 busy low", M2'(bz1), '0);
    end

    // R2: x^162 * x for the 163-bit polynomial
    run_u0(M1'(1) << 162, M1'(2), r, cyc);
    check(r == M1'('hC9), "R2 serial reduction", M2'(r), M2'('hC9));
    run_u1(M1'(1) << 162, M1'(2));
    check(p1 == M1'('hC9), "R2 unrolled reduction", M2'(p1), M2'('hC9));

    // R3: x^232 * x for the 233-bit polynomial
    run_u3(M2'(1) << 232, M2'(2), q, cyc);
    e = (M2'(1) << 74) | M2'(1);
    check(q == e, "R3 233 reduction", q, e);
    check(cyc == M2 + 1, "R3 233 latency", M2'(cyc), M2'(M2 + 1));
    for (int i = 0; i < 3; i++) begin
      logic [M2-1:0] ra, rb;
      ra = rnd(M2); rb = rnd(M2);
      e = ref_mul(ra, rb, M2);
      run_u3(ra, rb, q, cyc);
      check(q == e, "R6 random 233", q, e);
    end

    // R4: identity and zero
    x = rnd(M1);
    run_u0(x, M1'(1), r, cyc);
    check(r == x, "R4 times one serial", M2'(r), M2'(x));
    run_u0(x, '0, r, cyc);
    check(r == '0, "R4 times zero serial", M2'(r), '0);
    run_u1(M1'(1), x);
    check(p1 == x, "R4 one times U unrolled", M2'(p1), M2'(x));

    // R5: commutativity, R6 random, R11 squarer ignores op_b
    for (int i = 0; i < 12; i++) begin
      x = rnd(M1); y = rnd(M1);
      e = ref_mul(M2'(x), M2'(y), M1);
      run_u0(x, y, r, cyc);
      run_u0(y, x, r2, cyc);
      check(r == r2, "R5 commutative", M2'(r2), M2'(r));
      check(r == e[M1-1:0], "R6 random serial", M2'(r), e);
      run_u1(x, y);
      check(p1 == e[M1-1:0], "R6 random unrolled", M2'(p1), e);
      e = ref_mul(M2'(x), M2'(x), M1);
      check(p2 == e[M1-1:0], "R11 squarer", M2'(p2), e);
    end

    // R8: start while busy is ignored
    x = rnd(M1); y = rnd(M1);
    e = ref_mul(M2'(x), M2'(y), M1);
    @(negedge clk); a1 = x; b1 = y; st0 = 1;
    @(negedge clk); st0 = 0; cyc = 1;
    repeat (10) begin @(negedge clk); cyc++; end
    a1 = rnd(M1); b1 = rnd(M1); st0 = 1;
    @(negedge clk); st0 = 0; cyc++;
    while (!dn0 && cyc < 2000) begin @(negedge clk); cyc++; end
    check(p0 == e[M1-1:0], "R8 busy start ignored result", M2'(p0), e);
    check(cyc == M1 + 1, "R8 busy start ignored timing", M2'(cyc), M2'(M1 + 1));

    // R9: product holds while done is low
    r = p0;
    repeat (6) begin
      @(negedge clk); a1 = rnd(M1); b1 = rnd(M1);
    end
    check(p0 == r && !dn0, "R9 serial hold", M2'(p0), M2'(r));
    r = p1;
    check(p1 == r && !dn1, "R9 unrolled hold", M2'(p1), M2'(r));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule